// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is an interval timer built around a down-counter with automatic reload. Software sets it up through a small synchronous register port. A reload value goes into the base register. A load request copies that value into the counter. Setting the enable bit then starts counting. The counter steps down once for every strobe of the selected clock-enable source. After the count has reached zero, the next strobe reloads the base value, emits a one-cycle interrupt pulse and sets a sticky status flag. The interrupt rate is therefore the selected strobe rate divided by the base value plus one.

The block has four clock-enable inputs, each a single-cycle strobe in the system clock domain. A two-bit field in the mode register picks one of them. The select field is frozen while the timer is enabled, so it cannot be changed in the middle of a count.

Top module: `rld_timer`

## Requirements
- R1: After reset, reads of the mode, base, count and status registers all return 0, and `irqPulse` is low.
- R2: Address 1 holds the base value. A write of any value from 0 to 255 reads back unchanged.
- R3: Address 0 is the mode register: bit 0 enable, bit 1 load, bits 3:2 source select, and the upper bits read 0. While load is 1, the counter takes the base value on every clock and never decrements, even when enable is also 1.
- R4: Select encoding i (00, 01, 10, 11) picks `tickIn[i]`. With enable 1 and load 0, the counter drops by one on each strobe of the chosen input only. A strobe in the clock cycle right after the enabling write already counts.
- R5: When a strobe arrives with the count at 0, the counter reloads the base value and `irqPulse` is high for exactly the next cycle. Interrupts therefore come every base+1 strobes: base 1 halves the strobe rate and base 0 gives one interrupt per strobe.
- R6: While enable is 0 and load is 0, the count holds its value and no interrupt is raised.
- R7: Bit 0 at address 3 is a sticky status flag. An underflow sets it. Writing 1 to that bit clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: A mode write made while enable is currently 1 leaves the select field unchanged. The enable and load bits still take the written values.
- R9: Address 2 returns the current count. Reading it any number of times does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 mode, 1 base, 2 count, 3 status) |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Read data for `regAddr`, combinational |
| tickIn | input | 4 | Clock-enable strobes, bit i chosen by select value i |
| irqPulse | output | 1 | One-cycle underflow interrupt request |

## Verification
The bench builds the block at the default width of 8 bits. At that width the full base range from 0 to 255 is reachable, including the two extremes: base 0, which gives one interrupt per strobe, and base 255, which exercises the widest reload. Each of the four strobe inputs runs at its own rate: period 4, period 8, strobes driven one at a time by hand, and period 3. The measured interrupt spacings (16, 32, 8 and 3 cycles) therefore tell whether the correct input was picked and whether the base+1 ratio holds.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;
  localparam int ADDR_W = 2;
  localparam int SEL_W = 2;
  localparam int NUM_SRC = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic ld;
    logic en;
  } mode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBase;
    logic dec;
  } cnt_cmd_t;
endpackage

// File: rtl/rld_timer_ctrl.sv
module rld_timer_ctrl
  import rld_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [CNT_W-1:0]     regWrData,
  output logic [CNT_W-1:0]     regRdData,
  input  logic [NUM_SRC-1:0]   tickIn,
  input  logic [CNT_W-1:0]     cntVal,
  input  logic                 cntZero,
  output cnt_cmd_t             cmd,
  output logic [CNT_W-1:0]     baseVal,
  output mode_t                modeVal,
  output logic                 tickSel,
  output logic                 statFlag,
  output logic                 irqPulse
);
  localparam int MODE_W = $bits(mode_t);
  localparam int PAD_W = CNT_W - MODE_W;

  mode_t modeQ;
  logic [CNT_W-1:0] baseQ;
  logic statQ;
  logic irqQ;
  logic underflow;
  logic modeWr, baseWr, statClr;

  assign modeWr = regWrEn && (regAddr == ADDR_MODE);
  assign baseWr = regWrEn && (regAddr == ADDR_BASE);
  assign statClr = regWrEn && (regAddr == ADDR_STAT) && regWrData[0];

  // Strobe selection, one leg per source
  logic [NUM_SRC-1:0] selHit;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign selHit[i] = tickIn[i] && (modeQ.sel == SEL_W'(i));
  end
  assign tickSel = |selHit;

  always_comb begin
    cmd = '0;
    underflow = 1'b0;
    if (modeQ.ld) begin
      cmd.loadBase = 1'b1;
    end else if (modeQ.en && tickSel) begin
      if (cntZero) begin
        cmd.loadBase = 1'b1;
        underflow = 1'b1;
      end else begin
        cmd.dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      baseQ <= '0;
      statQ <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      irqQ <= underflow;
      if (underflow) statQ <= 1'b1;
      else if (statClr) statQ <= 1'b0;
      if (baseWr) baseQ <= regWrData;
      if (modeWr) begin
        modeQ.en <= regWrData[0];
        modeQ.ld <= regWrData[1];
        if (!modeQ.en) modeQ.sel <= regWrData[SEL_W+1:2];
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_MODE: regRdData = {{PAD_W{1'b0}}, modeQ};
      ADDR_BASE: regRdData = baseQ;
      ADDR_COUNT: regRdData = cntVal;
      default: regRdData = {{(CNT_W-1){1'b0}}, statQ};
    endcase
  end

  assign baseVal = baseQ;
  assign modeVal = modeQ;
  assign statFlag = statQ;
  assign irqPulse = irqQ;
endmodule

// File: rtl/rld_timer_dpath.sv
module rld_timer_dpath
  import rld_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_cmd_t         cmd,
  input  logic [CNT_W-1:0] baseVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             cntZero
);
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (cmd.loadBase) cntQ <= baseVal;
    else if (cmd.dec) cntQ <= cntQ - CNT_W'(1);
  end

  assign cntVal = cntQ;
  assign cntZero = (cntQ == '0);
endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import rld_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [CNT_W-1:0]   regWrData,
  output logic [CNT_W-1:0]   regRdData,
  input  logic [3:0]         tickIn,
  output logic               irqPulse
);
  cnt_cmd_t cmd;
  mode_t modeNow;
  logic [CNT_W-1:0] baseNow, cntNow;
  logic cntZero, tickNow, statNow;

  rld_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tickIn(tickIn),
    .cntVal(cntNow), .cntZero(cntZero), .cmd(cmd), .baseVal(baseNow),
    .modeVal(modeNow), .tickSel(tickNow), .statFlag(statNow),
    .irqPulse(irqPulse)
  );

  rld_timer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .baseVal(baseNow),
    .cntVal(cntNow), .cntZero(cntZero)
  );
endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk
  import rld_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input mode_t            modeNow,
  input logic [CNT_W-1:0] baseNow,
  input logic [CNT_W-1:0] cntNow,
  input logic             tickNow,
  input logic             statNow,
  input logic             irqPulse
);
  // R3
  load_copies_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeNow.ld |=> cntNow == $past(baseNow));
  // R4
  tick_decrements_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow.en && !modeNow.ld && tickNow && cntNow != '0)
      |=> cntNow == $past(cntNow) - CNT_W'(1));
  // R5
  underflow_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow.en && !modeNow.ld && tickNow && cntNow == '0)
      |=> irqPulse && cntNow == $past(baseNow));
  // R6
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeNow.en && !modeNow.ld) |=> $stable(cntNow) && !irqPulse);
  // R7
  irq_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> statNow);
  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeNow.en |=> $stable(modeNow.sel));
endmodule

bind rld_timer rld_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeNow(modeNow), .baseNow(baseNow),
  .cntNow(cntNow), .tickNow(tickNow), .statNow(statNow),
  .irqPulse(irqPulse)
);

// File: tb/tb_rld_timer.sv
module tb_rld_timer;
  localparam int W = 8;

  logic clk = 0, rstN = 0, regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [W-1:0] regWrData = 0;
  logic [W-1:0] regRdData;
  logic [3:0] tickIn;
  logic irqPulse;
  logic extTick = 0;
  int cyc = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  rld_timer #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tickIn(tickIn),
    .irqPulse(irqPulse)
  );

  // strobe sources: period 4, period 8, manual, period 3
  always @(posedge clk) begin
    #1;
    cyc++;
  end
  assign tickIn = {(cyc % 3 == 0), extTick, (cyc % 8 == 0), (cyc % 4 == 0)};

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mEn, mLd, mSel, mBase, mCnt, mStat, mIrq;
  always @(posedge clk) begin
    int tk, nCnt, nIrq, nStat;
    if (!rstN) begin
      mEn = 0; mLd = 0; mSel = 0; mBase = 0; mCnt = 0; mStat = 0; mIrq = 0;
    end else begin
      tk = tickIn[mSel];
      nCnt = mCnt; nIrq = 0; nStat = mStat;
      if (mLd != 0) nCnt = mBase;
      else if (mEn != 0 && tk != 0) begin
        if (mCnt == 0) begin nCnt = mBase; nIrq = 1; nStat = 1; end
        else nCnt = mCnt - 1;
      end
      if (regWrEn && regAddr == 3 && regWrData[0] && nIrq == 0) nStat = 0;
      if (regWrEn && regAddr == 0) begin
        if (mEn == 0) mSel = regWrData[3:2];
        mEn = regWrData[0];
        mLd = regWrData[1];
      end
      if (regWrEn && regAddr == 1) mBase = regWrData;
      mCnt = nCnt; mIrq = nIrq; mStat = nStat;
    end
  end

  function automatic int modelRead(int a);
    case (a)
      0: return mEn + 2 * mLd + 4 * mSel;
      1: return mBase;
      2: return mCnt;
      default: return mStat;
    endcase
  endfunction

  // cycle-by-cycle comparison (R4/R5/R7 behaviour over time)
  always @(negedge clk) begin
    if (rstN) begin
      check("R5 model irq", irqPulse, mIrq);
      check("R4 model read", regRdData, modelRead(regAddr));
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    regWrEn = 1; regAddr = a[1:0]; regWrData = d[W-1:0];
    @(posedge clk); #2;
    regWrEn = 0;
  endtask

  task automatic rd(int a, output int v);
    @(posedge clk); #2;
    regAddr = a[1:0];
    @(negedge clk);
    v = regRdData;
  endtask

  task automatic measure(output int gap);
    gap = 0;
    do @(negedge clk); while (!irqPulse);
    do begin @(negedge clk); gap++; end while (!irqPulse);
  endtask

  initial begin
    int v, v2, gap, irqSeen;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    check("R1 irq after reset", irqPulse, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      check("R1 reset value", v, 0);
    end
    // R2 base readback extremes
    wr(1, 5); rd(1, v); check("R2 base 5", v, 5);
    wr(1, 255); rd(1, v); check("R2 base 255", v, 255);
    wr(1, 0); rd(1, v); check("R2 base 0", v, 0);
    wr(1, 255);
    // R3 load copies base, no decrement while load with enable
    wr(0, 2); rd(2, v); check("R3 load copies base", v, 255);
    wr(0, 3); repeat (20) @(posedge clk);
    rd(2, v); check("R3 load blocks decrement", v, 255);
    rd(0, v); check("R3 mode layout", v, 3);
    // R5 base 3 on period-4 source -> 16 cycles
    wr(0, 0); wr(1, 3); wr(0, 2); wr(0, 1);
    measure(gap); check("R5 interval base 3 sel 00", gap, 16);
    // R7 status set and clear
    rd(3, v); check("R7 status set", v, 1);
    wr(3, 1); rd(3, v); check("R7 status cleared", v, 0);
    // R8 select frozen while enabled
    wr(0, 5); rd(0, v); check("R8 sel kept while enabled", v, 1);
    // R6 disabled holds
    wr(0, 4); rd(0, v); check("R8 sel kept, enable cleared", v, 0);
    rd(2, v); irqSeen = 0;
    repeat (40) begin @(negedge clk); if (irqPulse) irqSeen++; end
    rd(2, v2); check("R6 count held", v2, v);
    check("R6 no irq when disabled", irqSeen, 0);
    wr(0, 4); rd(0, v); check("R8 sel accepted when disabled", v, 4);
    // R4 period-8 source, base 3 -> 32
    wr(1, 3); wr(0, 6); wr(0, 5);
    measure(gap); check("R4 interval sel 01", gap, 32);
    // R4 manual strobes on source 10, first one right after enabling write
    wr(0, 0); wr(0, 8 + 2); wr(0, 8);
    @(posedge clk); #2 regWrEn = 1; regAddr = 0; regWrData = 9;
    @(posedge clk); #2 regWrEn = 0; extTick = 1;
    @(posedge clk); #2 extTick = 0;
    rd(2, v); check("R4 first strobe after enable counts", v, 2);
    @(posedge clk); #2 extTick = 1;
    @(posedge clk); #2 extTick = 0;
    rd(2, v); check("R4 manual strobe", v, 1);
    // R9 reads do not disturb
    for (int i = 0; i < 5; i++) begin
      rd(2, v); check("R9 repeated read", v, 1);
    end
    // R5 base 1 divides by two: 8 cycles on period-4 source
    wr(0, 0); wr(1, 1); wr(0, 2); wr(0, 1);
    measure(gap); check("R5 divide by two", gap, 8);
    // R4/R5 base 0 on period-3 source: irq every strobe
    wr(0, 0); wr(1, 0); wr(0, 2); wr(0, 13);
    measure(gap); check("R5 base 0 sel 11", gap, 3);
    // R7 clear vs set same cycle: set wins
    do @(negedge clk); while (!(tickIn[3] && mCnt == 0));
    // write lands on the edge where the underflow happens
    regWrEn = 1; regAddr = 3; regWrData = 1;
    @(posedge clk); #2 regWrEn = 0;
    rd(3, v); check("R7 set wins over clear", v, 1);
    wr(0, 0);
    repeat (5) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule